// File: doc/BRIEF.md
# Large-ROM Bank Controller with 9-bit ROM Bank

This block sits between a CPU's 16-bit address bus and a cartridge-style ROM of up to 512 banks of 16 KiB and a RAM of up to 16 banks of 8 KiB. CPU writes into the lower half of the address space do not reach memory. They program control state: a RAM enable, a 9-bit ROM bank loaded through two separate write ranges, and a 4-bit RAM bank.

CPU reads and RAM writes are turned into a flat memory address and a memory select, registered one cycle after the strobe. A force flag tells the read path to return 0xFF in place of the memory byte when the access falls outside the configured ROM size. The flag is also raised when RAM is absent, disabled or out of range. The storage arrays sit outside the block. The ROM size and the RAM size are given as base-2 logarithms of the bank count, and a separate input says whether RAM is present.

Top module: `xbank_mapper`

## Requirements
- R1: After a synchronous reset the ROM bank is 1, the RAM bank is 0 and RAM is disabled, so a read of 0x4000 maps to flat address 0x4000 and a RAM read is forced to 0xFF.
- R2: A write in 0x0000–0x1FFF enables RAM only when the full data byte equals 0x0A; any other byte, including 0x1A, disables it.
- R3: A write in 0x2000–0x2FFF loads ROM bank bits 7:0 from the data and leaves bank bit 8 unchanged.
- R4: A write in 0x3000–0x3FFF loads ROM bank bit 8 from data bit 0 and leaves bank bits 7:0 unchanged.
- R5: ROM bank value 0 is honoured in the switchable window, so a read of 0x4ABC with bank 0 maps to flat 0x0ABC.
- R6: A read in 0x0000–0x3FFF selects ROM (map_sel = 1) at flat address equal to the CPU address, never forced.
- R7: A read in 0x4000–0x7FFF selects ROM at flat 0x4000 × bank + (address − 0x4000), and map_force_ff is 1 exactly when bank ≥ 2^rom_size_log2.
- R8: A write in 0x4000–0x5FFF loads the RAM bank from data bits 3:0.
- R9: A read in 0xA000–0xBFFF selects RAM (map_sel = 2) at flat 0x2000 × RAM bank + (address − 0xA000), and map_force_ff is 1 when ram_present is 0, RAM is disabled, or RAM bank ≥ 2^ram_size_log2.
- R10: A write in 0xA000–0xBFFF selects RAM at the same flat address, and map_ram_we is 1 only when RAM is present, enabled and in range; map_force_ff is 0 for every write.
- R11: Outputs appear on the clock edge after the strobe; a cycle with no strobe, or a read outside the ROM and RAM windows, gives map_sel = 0, map_force_ff = 0, map_ram_we = 0 and map_addr = 0.
- R12: A write in 0x6000–0x7FFF changes no bank or enable state and selects nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access; wins over cpu_rd |
| rom_size_log2 | input | 4 | log2 of ROM bank count (1..9) |
| ram_size_log2 | input | 3 | log2 of RAM bank count (0..4) |
| ram_present | input | 1 | RAM fitted |
| map_addr | output | 23 | Registered flat memory address |
| map_sel | output | 2 | 0 none, 1 ROM, 2 RAM |
| map_force_ff | output | 1 | Read must return 0xFF |
| map_ram_we | output | 1 | Commit RAM write at map_addr |

## Verification
The bound checker watches every cycle for the rules that follow from the ports alone. An idle cycle must give an empty output. A RAM write strobe must never be paired with a force flag. Fixed-bank reads must map straight through, and the switchable window must keep the offset bits. Reads with RAM absent must be forced, and so must a RAM read right after a non-key enable write. Writes to the unused range must select nothing. The bank arithmetic itself is left to the bench scenarios, which build up state across many writes. These include the split 9-bit bank loads, bank 0 in the switchable window, and the exact limits of the ROM and RAM range checks as the size inputs change. The bench also covers recovery after a reset in mid-run.

// File: rtl/xbank_pkg.sv
package xbank_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ROM  = 2'd1,
    SEL_RAM  = 2'd2
  } mem_sel_e;

  typedef enum logic [3:0] {
    RG_IDLE,
    RG_RAMEN,
    RG_BANKLO,
    RG_BANKHI,
    RG_RAMBANK,
    RG_ROM0,
    RG_ROMX,
    RG_RAM_RD,
    RG_RAM_WR
  } region_e;

endpackage

// File: rtl/xbank_decode.sv
module xbank_decode
  import xbank_pkg::*;
(
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  output region_e     region
);

  always_comb begin
    region = RG_IDLE;
    if (cpu_wr) begin
      if (cpu_addr[15:13] == 3'b000)       region = RG_RAMEN;
      else if (cpu_addr[15:12] == 4'b0010) region = RG_BANKLO;
      else if (cpu_addr[15:12] == 4'b0011) region = RG_BANKHI;
      else if (cpu_addr[15:13] == 3'b010)  region = RG_RAMBANK;
      else if (cpu_addr[15:13] == 3'b101)  region = RG_RAM_WR;
    end else if (cpu_rd) begin
      if (cpu_addr[15:14] == 2'b00)        region = RG_ROM0;
      else if (cpu_addr[15:14] == 2'b01)   region = RG_ROMX;
      else if (cpu_addr[15:13] == 3'b101)  region = RG_RAM_RD;
    end
  end

endmodule

// File: rtl/xbank_regs.sv
module xbank_regs
  import xbank_pkg::*;
#(
  parameter int unsigned ROM_BANK_W = 9,
  parameter int unsigned RAM_BANK_W = 4,
  parameter logic [7:0]  ENABLE_KEY = 8'h0A,
  localparam int unsigned LO_W = 8,
  localparam int unsigned HI_W = ROM_BANK_W - LO_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  region_e               region,
  input  logic [7:0]            cpu_wdata,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_bank <= ROM_BANK_W'(1);
      ram_bank <= '0;
      ram_en   <= 1'b0;
    end else begin
      case (region)
        RG_RAMEN:   ram_en   <= (cpu_wdata == ENABLE_KEY);
        RG_BANKLO:  rom_bank <= {rom_bank[ROM_BANK_W-1:LO_W], cpu_wdata};
        RG_BANKHI:  rom_bank <= {cpu_wdata[HI_W-1:0], rom_bank[LO_W-1:0]};
        RG_RAMBANK: ram_bank <= cpu_wdata[RAM_BANK_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/xbank_map.sv
module xbank_map
  import xbank_pkg::*;
#(
  parameter int unsigned ROM_BANK_W = 9,
  parameter int unsigned RAM_BANK_W = 4,
  parameter int unsigned ROM_OFF_W  = 14,
  parameter int unsigned RAM_OFF_W  = 13,
  localparam int unsigned ROM_AW = ROM_BANK_W + ROM_OFF_W,
  localparam int unsigned RAM_AW = RAM_BANK_W + RAM_OFF_W,
  localparam int unsigned OUT_AW = (ROM_AW > RAM_AW) ? ROM_AW : RAM_AW,
  localparam int unsigned ROM_CFG_W = $clog2(ROM_BANK_W + 1),
  localparam int unsigned RAM_CFG_W = $clog2(RAM_BANK_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  region_e               region,
  input  logic [ROM_OFF_W-1:0]  offset,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  input  logic [RAM_BANK_W-1:0] ram_bank,
  input  logic                  ram_en,
  input  logic                  ram_present,
  input  logic [ROM_CFG_W-1:0]  rom_size_log2,
  input  logic [RAM_CFG_W-1:0]  ram_size_log2,
  output logic [OUT_AW-1:0]     map_addr,
  output logic [1:0]            map_sel,
  output logic                  map_force_ff,
  output logic                  map_ram_we
);

  logic              rom_oor, ram_oor, ram_ok;
  logic [ROM_AW-1:0] rom_flat;
  logic [RAM_AW-1:0] ram_flat;
  logic [OUT_AW-1:0] nxt_addr;
  mem_sel_e          nxt_sel;
  logic              nxt_ff, nxt_we;

  assign rom_oor  = (rom_bank >> rom_size_log2) != '0;
  assign ram_oor  = (ram_bank >> ram_size_log2) != '0;
  assign ram_ok   = ram_present && ram_en && !ram_oor;
  assign rom_flat = {rom_bank, offset};
  assign ram_flat = {ram_bank, offset[RAM_OFF_W-1:0]};

  always_comb begin
    nxt_addr = '0;
    nxt_sel  = SEL_NONE;
    nxt_ff   = 1'b0;
    nxt_we   = 1'b0;
    case (region)
      RG_ROM0: begin
        nxt_sel  = SEL_ROM;
        nxt_addr = OUT_AW'(offset);
      end
      RG_ROMX: begin
        nxt_sel  = SEL_ROM;
        nxt_addr = OUT_AW'(rom_flat);
        nxt_ff   = rom_oor;
      end
      RG_RAM_RD: begin
        nxt_sel  = SEL_RAM;
        nxt_addr = OUT_AW'(ram_flat);
        nxt_ff   = !ram_ok;
      end
      RG_RAM_WR: begin
        nxt_sel  = SEL_RAM;
        nxt_addr = OUT_AW'(ram_flat);
        nxt_we   = ram_ok;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_addr     <= '0;
      map_sel      <= SEL_NONE;
      map_force_ff <= 1'b0;
      map_ram_we   <= 1'b0;
    end else begin
      map_addr     <= nxt_addr;
      map_sel      <= nxt_sel;
      map_force_ff <= nxt_ff;
      map_ram_we   <= nxt_we;
    end
  end

endmodule

// File: rtl/xbank_mapper.sv
module xbank_mapper
  import xbank_pkg::*;
#(
  parameter int unsigned ROM_BANK_W = 9,
  parameter int unsigned RAM_BANK_W = 4,
  parameter int unsigned ROM_OFF_W  = 14,
  parameter int unsigned RAM_OFF_W  = 13,
  localparam int unsigned ROM_AW = ROM_BANK_W + ROM_OFF_W,
  localparam int unsigned RAM_AW = RAM_BANK_W + RAM_OFF_W,
  localparam int unsigned OUT_AW = (ROM_AW > RAM_AW) ? ROM_AW : RAM_AW,
  localparam int unsigned ROM_CFG_W = $clog2(ROM_BANK_W + 1),
  localparam int unsigned RAM_CFG_W = $clog2(RAM_BANK_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [15:0]          cpu_addr,
  input  logic [7:0]           cpu_wdata,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  input  logic [ROM_CFG_W-1:0] rom_size_log2,
  input  logic [RAM_CFG_W-1:0] ram_size_log2,
  input  logic                 ram_present,
  output logic [OUT_AW-1:0]    map_addr,
  output logic [1:0]           map_sel,
  output logic                 map_force_ff,
  output logic                 map_ram_we
);

  region_e               region;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic                  ram_en;

  xbank_decode u_decode (
    .cpu_addr (cpu_addr),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .region   (region)
  );

  xbank_regs #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .region    (region),
    .cpu_wdata (cpu_wdata),
    .rom_bank  (rom_bank),
    .ram_bank  (ram_bank),
    .ram_en    (ram_en)
  );

  xbank_map #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W),
    .ROM_OFF_W  (ROM_OFF_W),
    .RAM_OFF_W  (RAM_OFF_W)
  ) u_map (
    .clk           (clk),
    .rst           (rst),
    .region        (region),
    .offset        (cpu_addr[ROM_OFF_W-1:0]),
    .rom_bank      (rom_bank),
    .ram_bank      (ram_bank),
    .ram_en        (ram_en),
    .ram_present   (ram_present),
    .rom_size_log2 (rom_size_log2),
    .ram_size_log2 (ram_size_log2),
    .map_addr      (map_addr),
    .map_sel       (map_sel),
    .map_force_ff  (map_force_ff),
    .map_ram_we    (map_ram_we)
  );

endmodule

// File: rtl/xbank_mapper_chk.sv
module xbank_mapper_chk #(
  parameter int unsigned OUT_AW = 23
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              ram_present,
  input logic [OUT_AW-1:0] map_addr,
  input logic [1:0]        map_sel,
  input logic              map_force_ff,
  input logic              map_ram_we
);

  logic rd_only;
  assign rd_only = cpu_rd && !cpu_wr;

  assert_idle_empty_R11: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd && !cpu_wr) |=> (map_sel == 2'd0 && !map_force_ff && !map_ram_we && map_addr == '0));

  assert_we_clean_R10: assert property (@(posedge clk) disable iff (rst)
    map_ram_we |-> (map_sel == 2'd2 && !map_force_ff));

  assert_absent_forced_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_only && cpu_addr[15:13] == 3'b101 && !ram_present) |=> (map_sel == 2'd2 && map_force_ff));

  assert_fixed_direct_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_only && cpu_addr[15:14] == 2'b00)
      |=> (map_sel == 2'd1 && !map_force_ff && map_addr == OUT_AW'($past(cpu_addr[13:0]))));

  assert_window_offset_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_only && cpu_addr[15:14] == 2'b01)
      |=> (map_sel == 2'd1 && map_addr[13:0] == $past(cpu_addr[13:0])));

  assert_nonkey_disables_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata != 8'h0A)
      ##1 (rd_only && cpu_addr[15:13] == 3'b101) |=> map_force_ff);

  assert_unused_range_R12: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15:13] == 3'b011) |=> (map_sel == 2'd0 && !map_ram_we));

endmodule

bind xbank_mapper xbank_mapper_chk #(.OUT_AW(OUT_AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_addr     (cpu_addr),
  .cpu_wdata    (cpu_wdata),
  .cpu_rd       (cpu_rd),
  .cpu_wr       (cpu_wr),
  .ram_present  (ram_present),
  .map_addr     (map_addr),
  .map_sel      (map_sel),
  .map_force_ff (map_force_ff),
  .map_ram_we   (map_ram_we)
);

// File: tb/xbank_mapper_tb.sv
module xbank_mapper_tb;

  localparam logic [1:0] OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [1:0]  sel;
    logic        ff;
    logic        we;
    logic [22:0] faddr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  // Sizes during the table: 64 ROM banks, 4 RAM banks, RAM fitted.
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 16'h4123, 8'h00, 2'd1, 1'b0, 1'b0, 23'h004123, 4'd1},  // R1 bank 1 after reset
    '{OP_RD, 16'hA010, 8'h00, 2'd2, 1'b1, 1'b0, 23'h000010, 4'd1},  // R1 RAM disabled
    '{OP_WR, 16'h0000, 8'h0A, 2'd0, 1'b0, 1'b0, 23'h000000, 4'd2},  // R2 enable key
    '{OP_RD, 16'hA010, 8'h00, 2'd2, 1'b0, 1'b0, 23'h000010, 4'd2},  // R2 enabled
    '{OP_WR, 16'hA020, 8'h55, 2'd2, 1'b0, 1'b1, 23'h000020, 4'd10}, // R10 commit
    '{OP_WR, 16'h2100, 8'h25, 2'd0, 1'b0, 1'b0, 23'h000000, 4'd3},  // R3 low byte
    '{OP_RD, 16'h7FFF, 8'h00, 2'd1, 1'b0, 1'b0, 23'h097FFF, 4'd7},  // R7 bank 0x25
    '{OP_WR, 16'h3000, 8'h01, 2'd0, 1'b0, 1'b0, 23'h000000, 4'd4},  // R4 bit 8
    '{OP_RD, 16'h4000, 8'h00, 2'd1, 1'b1, 1'b0, 23'h494000, 4'd4},  // R4 bank 0x125 oor
    '{OP_WR, 16'h2FFF, 8'h00, 2'd0, 1'b0, 1'b0, 23'h000000, 4'd3},  // R3 keeps bit 8
    '{OP_RD, 16'h4001, 8'h00, 2'd1, 1'b1, 1'b0, 23'h400001, 4'd3},  // R3 bank 0x100
    '{OP_WR, 16'h3FFF, 8'hFE, 2'd0, 1'b0, 1'b0, 23'h000000, 4'd4},  // R4 clears bit 8
    '{OP_RD, 16'h4ABC, 8'h00, 2'd1, 1'b0, 1'b0, 23'h000ABC, 4'd5},  // R5 bank 0
    '{OP_RD, 16'h1234, 8'h00, 2'd1, 1'b0, 1'b0, 23'h001234, 4'd6},  // R6 fixed window
    '{OP_WR, 16'h6000, 8'hFF, 2'd0, 1'b0, 1'b0, 23'h000000, 4'd12}, // R12 ignored
    '{OP_RD, 16'h5555, 8'h00, 2'd1, 1'b0, 1'b0, 23'h001555, 4'd12}, // R12 bank still 0
    '{OP_RD, 16'hA002, 8'h00, 2'd2, 1'b0, 1'b0, 23'h000002, 4'd12}, // R12 RAM still on
    '{OP_WR, 16'h4000, 8'hF3, 2'd0, 1'b0, 1'b0, 23'h000000, 4'd8},  // R8 low nibble
    '{OP_RD, 16'hBFFF, 8'h00, 2'd2, 1'b0, 1'b0, 23'h007FFF, 4'd8},  // R8 RAM bank 3
    '{OP_WR, 16'h5FFF, 8'h04, 2'd0, 1'b0, 1'b0, 23'h000000, 4'd8},  // R8 bank 4
    '{OP_RD, 16'hA000, 8'h00, 2'd2, 1'b1, 1'b0, 23'h008000, 4'd9},  // R9 out of range
    '{OP_WR, 16'hA000, 8'h11, 2'd2, 1'b0, 1'b0, 23'h008000, 4'd10}, // R10 oor write
    '{OP_WR, 16'h0000, 8'h1A, 2'd0, 1'b0, 1'b0, 23'h000000, 4'd2},  // R2 near key
    '{OP_WR, 16'h4000, 8'h01, 2'd0, 1'b0, 1'b0, 23'h000000, 4'd8},  // R8 bank 1
    '{OP_RD, 16'hA001, 8'h00, 2'd2, 1'b1, 1'b0, 23'h002001, 4'd2},  // R2 disabled
    '{OP_WR, 16'hA001, 8'h77, 2'd2, 1'b0, 1'b0, 23'h002001, 4'd10}, // R10 disabled write
    '{OP_IDLE, 16'h4000, 8'h00, 2'd0, 1'b0, 1'b0, 23'h000000, 4'd11}, // R11 idle
    '{OP_RD, 16'h8000, 8'h00, 2'd0, 1'b0, 1'b0, 23'h000000, 4'd11}  // R11 unmapped
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [3:0]  rom_size_log2 = 4'd6;
  logic [2:0]  ram_size_log2 = 3'd2;
  logic        ram_present = 1'b1;
  logic [22:0] map_addr;
  logic [1:0]  map_sel;
  logic        map_force_ff, map_ram_we;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xbank_mapper u_dut (
    .clk           (clk),
    .rst           (rst),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .cpu_rd        (cpu_rd),
    .cpu_wr        (cpu_wr),
    .rom_size_log2 (rom_size_log2),
    .ram_size_log2 (ram_size_log2),
    .ram_present   (ram_present),
    .map_addr      (map_addr),
    .map_sel       (map_sel),
    .map_force_ff  (map_force_ff),
    .map_ram_we    (map_ram_we)
  );

  task automatic do_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_rd    = (op == OP_RD);
    cpu_wr    = (op == OP_WR);
    @(negedge clk);
    cpu_rd = 1'b0;
    cpu_wr = 1'b0;
  endtask

  task automatic check(input string req, input logic [1:0] sel, input logic ff,
                       input logic we, input logic [22:0] fa);
    checks++;
    if (map_sel !== sel || map_force_ff !== ff || map_ram_we !== we || map_addr !== fa) begin
      errors++;
      $display("FAIL %s: got sel=%0d ff=%0b we=%0b addr=%06h, expected sel=%0d ff=%0b we=%0b addr=%06h",
               req, map_sel, map_force_ff, map_ram_we, map_addr, sel, ff, we, fa);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 2'd0, 1'b0, 1'b0, 23'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].op, VECS[i].addr, VECS[i].data);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            VECS[i].sel, VECS[i].ff, VECS[i].we, VECS[i].faddr);
    end

    // R9 / R10: RAM absent forces reads and blocks writes even when enabled
    ram_present = 1'b0;
    do_op(OP_WR, 16'h0000, 8'h0A);
    do_op(OP_RD, 16'hA005, 8'h00);
    check("R9 absent read", 2'd2, 1'b1, 1'b0, 23'h002005);
    do_op(OP_WR, 16'hA005, 8'h33);
    check("R10 absent write", 2'd2, 1'b0, 1'b0, 23'h002005);
    ram_present = 1'b1;
    do_op(OP_RD, 16'hA005, 8'h00);
    check("R9 present read", 2'd2, 1'b0, 1'b0, 23'h002005);

    // R7: top bank against full and halved ROM sizes
    do_op(OP_WR, 16'h2000, 8'hFF);
    do_op(OP_WR, 16'h3000, 8'h01);
    rom_size_log2 = 4'd9;
    do_op(OP_RD, 16'h7FFF, 8'h00);
    check("R7 bank 0x1FF of 512", 2'd1, 1'b0, 1'b0, 23'h7FFFFF);
    rom_size_log2 = 4'd8;
    do_op(OP_RD, 16'h7FFF, 8'h00);
    check("R7 bank 0x1FF of 256", 2'd1, 1'b1, 1'b0, 23'h7FFFFF);

    // R9: RAM bank 3 at the size edge
    do_op(OP_WR, 16'h4000, 8'h03);
    do_op(OP_RD, 16'hA000, 8'h00);
    check("R9 bank 3 of 4", 2'd2, 1'b0, 1'b0, 23'h006000);
    ram_size_log2 = 3'd1;
    do_op(OP_RD, 16'hA000, 8'h00);
    check("R9 bank 3 of 2", 2'd2, 1'b1, 1'b0, 23'h006000);

    // R1: reset in mid-run restores bank 1, bank 0, RAM off
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 outputs in reset", 2'd0, 1'b0, 1'b0, 23'h0);
    rst = 1'b0;
    ram_size_log2 = 3'd2;
    do_op(OP_RD, 16'h4000, 8'h00);
    check("R1 ROM bank 1", 2'd1, 1'b0, 1'b0, 23'h004000);
    do_op(OP_RD, 16'hA000, 8'h00);
    check("R1 RAM off bank 0", 2'd2, 1'b1, 1'b0, 23'h000000);
    @(negedge clk);
    check("R11 idle after read", 2'd0, 1'b0, 1'b0, 23'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule